// File: doc/BRIEF.md
# DDR SDRAM Start-up Command Sequencer

This block sits on the controller side of a DDR SDRAM interface. It brings a memory device from power-on to a usable state. After reset it keeps the clock-enable pin low while the supply and clock settle. It then raises clock enable during a no-operation slot and steps through a fixed list of commands. The list is: close all banks, write the extended register to turn the DLL on, write the main register to reset the DLL, wait for the DLL to lock, close all banks again, run a set of auto-refresh cycles, and make a final main-register write with the operating settings. The block drives exactly one command slot per clock, and each command output is registered.

The settle time is given in microseconds. The block turns it into a clock count from a clock-period parameter in picoseconds and rounds the result up. The other gaps are parameters counted in clock cycles: the precharge recovery, the register-write spacing, the refresh spacing and the DLL lock wait. The operating read latency is given in half cycles. It is encoded together with burst length, burst type and output drive strength into the register words. When the final register write has settled, `init_done` rises and stays high. From then on the pins rest at no-operation, ready to be handed to the normal traffic controller.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` and `init_done` are low and the pins carry a no-operation.
- R2: `cke` stays low for SETTLE = ceil(STABLE_US*1,000,000 / CLK_PERIOD_PS) cycles after reset release (output cycles 0..SETTLE-1). It rises at cycle SETTLE together with a no-operation and never falls again.
- R3: Every slot without a command is a no-operation: cs_n=0, ras_n=1, cas_n=1, we_n=1, with ba and addr all zero. No command other than a no-operation appears while `cke` is low.
- R4: The first command is close-all-banks at cycle SETTLE+1. It is encoded as cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr[10]=1 and ba=0.
- R5: T_RP cycles after the first close-all comes the extended register write. It has all four strobes low, ba=2'b01, addr[0]=0 (DLL on), addr[1]=DRIVE_HALF, and every other addr bit 0.
- R6: T_MRD cycles after the extended write comes the DLL-reset main register write. It has all four strobes low, ba=0, addr[8]=1, addr[7]=0 and the operating fields of R10.
- R7: The next command after the DLL reset, a second close-all-banks, comes exactly DLL_LOCK_CYC cycles after it.
- R8: NUM_REFRESH auto-refresh commands follow (cs_n=0, ras_n=0, cas_n=0, we_n=1, ba and addr 0). The first comes T_RP cycles after the second close-all, and each later one comes T_RFC cycles after the one before.
- R9: T_RFC cycles after the last refresh comes the final main register write, with ba=0, addr[8]=0, addr[7]=0 and the operating fields of R10.
- R10: In both main register writes, addr[6:4] is the read latency code: 2 gives 010, 2.5 gives 110, 3 gives 011 (READ_LAT_X2 = 4, 5, 6). addr[3] is 1 for interleaved bursts. addr[2:0] is the burst length code: 2 gives 001, 4 gives 010, 8 gives 011. addr[11:9] is 0.
- R11: `init_done` rises T_MRD cycles after the final register write. It stays high, and from then on every slot is a no-operation with `cke` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select bits |
| addr | output | 12 | Address bits A0..A11 |
| init_done | output | 1 | High once the start-up sequence is finished |

## Verification
The bench builds the block with a 7,000,000 ps clock period. This makes the 200 us settle time a 29-cycle wait, so the rounding up of a non-integral quotient is checked in a short run. It keeps the full 200-cycle DLL lock wait, and it sets three refresh commands, so the spacing between refreshes is checked more than once. It also chooses read latency 2.5, burst length 8, interleaved bursts and half drive strength. Each of these puts a non-default bit pattern into the register words: latency code 110 and drive-strength bit A1 set.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command slot kinds produced by the sequencer
    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_PRE_ALL = 3'd1,
        CMD_REFRESH = 3'd2,
        CMD_EXT_WR  = 3'd3,
        CMD_DLL_RST = 3'd4,
        CMD_OPER_WR = 3'd5
    } cmd_t;

    // Next step waiting to be issued once its gap counter expires
    typedef enum logic [3:0] {
        PH_RAISE_CKE = 4'd0,
        PH_PRE_A     = 4'd1,
        PH_EXT_WR    = 4'd2,
        PH_DLL_RST   = 4'd3,
        PH_PRE_B     = 4'd4,
        PH_REFRESH   = 4'd5,
        PH_OPER_WR   = 4'd6,
        PH_FINISH    = 4'd7,
        PH_HOLD      = 4'd8
    } phase_t;

    // Register word: bank bits plus address bits
    typedef struct packed {
        logic [1:0]  ba;
        logic [11:0] addr;
    } reg_word_t;

    // Read latency (in half cycles) to its 3-bit field code
    function automatic logic [2:0] lat_code(input int lat_x2);
        case (lat_x2)
            4:       lat_code = 3'b010;
            5:       lat_code = 3'b110;
            6:       lat_code = 3'b011;
            default: lat_code = 3'b010;
        endcase
    endfunction

    // Burst length to its 3-bit field code
    function automatic logic [2:0] len_code(input int blen);
        case (blen)
            2:       len_code = 3'b001;
            4:       len_code = 3'b010;
            8:       len_code = 3'b011;
            default: len_code = 3'b010;
        endcase
    endfunction

endpackage

// File: rtl/ddr_init_words.sv
module ddr_init_words
    import ddr_init_pkg::*;
#(
    parameter int READ_LAT_X2      = 4,
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter bit DRIVE_HALF       = 1'b0
) (
    output reg_word_t ext_word,
    output reg_word_t dll_rst_word,
    output reg_word_t oper_word
);

    localparam logic [2:0] LAT_F = lat_code(READ_LAT_X2);
    localparam logic [2:0] LEN_F = len_code(BURST_LEN);

    // Operating fields shared by both main-register writes
    logic [6:0] oper_fields;
    assign oper_fields = {LAT_F, BURST_INTERLEAVE, LEN_F};

    // Extended register: DLL on (A0=0), drive strength in A1
    assign ext_word.ba   = 2'b01;
    assign ext_word.addr = {10'd0, DRIVE_HALF, 1'b0};

    // Main register with DLL reset (A8=1), test bit A7 held low
    assign dll_rst_word.ba   = 2'b00;
    assign dll_rst_word.addr = {3'b000, 1'b1, 1'b0, oper_fields};

    // Main register, normal operation
    assign oper_word.ba   = 2'b00;
    assign oper_word.addr = {3'b000, 1'b0, 1'b0, oper_fields};

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
(
    input  cmd_t        cmd,
    input  reg_word_t   ext_word,
    input  reg_word_t   dll_rst_word,
    input  reg_word_t   oper_word,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr
);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = 2'b00;
        addr  = 12'd0;
        case (cmd)
            CMD_PRE_ALL: begin
                ras_n    = 1'b0;
                we_n     = 1'b0;
                addr[10] = 1'b1;
            end
            CMD_REFRESH: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_EXT_WR: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = ext_word.ba;
                addr  = ext_word.addr;
            end
            CMD_DLL_RST: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = dll_rst_word.ba;
                addr  = dll_rst_word.addr;
            end
            CMD_OPER_WR: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = oper_word.ba;
                addr  = oper_word.addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS    = 5000,
    parameter int STABLE_US        = 200,
    parameter int DLL_LOCK_CYC     = 200,
    parameter int T_RP_CYC         = 3,
    parameter int T_MRD_CYC        = 2,
    parameter int T_RFC_CYC        = 14,
    parameter int NUM_REFRESH      = 2,
    parameter int READ_LAT_X2      = 4,
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter bit DRIVE_HALF       = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr,
    output logic        init_done
);

    // Settle time in cycles, rounded up
    localparam longint SETTLE_NUM = longint'(STABLE_US) * 64'd1_000_000;
    localparam int SETTLE_CYC =
        int'((SETTLE_NUM + longint'(CLK_PERIOD_PS) - 1) / longint'(CLK_PERIOD_PS));

    localparam int MAX_A    = (SETTLE_CYC > DLL_LOCK_CYC) ? SETTLE_CYC : DLL_LOCK_CYC;
    localparam int MAX_B    = (T_RFC_CYC > T_RP_CYC) ? T_RFC_CYC : T_RP_CYC;
    localparam int MAX_C    = (MAX_B > T_MRD_CYC) ? MAX_B : T_MRD_CYC;
    localparam int MAX_WAIT = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int REF_W    = $clog2(NUM_REFRESH + 1);

    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] RP_LOAD     = CNT_W'(T_RP_CYC - 1);
    localparam logic [CNT_W-1:0] MRD_LOAD    = CNT_W'(T_MRD_CYC - 1);
    localparam logic [CNT_W-1:0] DLL_LOAD    = CNT_W'(DLL_LOCK_CYC - 1);
    localparam logic [CNT_W-1:0] RFC_LOAD    = CNT_W'(T_RFC_CYC - 1);
    localparam logic [REF_W-1:0] REF_LOAD    = REF_W'(NUM_REFRESH);

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] gap;
        logic [REF_W-1:0] refs_left;
        logic             cke;
        cmd_t             cmd;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    reg_word_t ext_word, dll_rst_word, oper_word;

    ddr_init_words #(
        .READ_LAT_X2      (READ_LAT_X2),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .DRIVE_HALF       (DRIVE_HALF)
    ) u_words (
        .ext_word     (ext_word),
        .dll_rst_word (dll_rst_word),
        .oper_word    (oper_word)
    );

    // Next-state logic: one slot per clock, NOP unless a gap has expired
    always_comb begin
        st_d     = st_q;
        st_d.cmd = CMD_NOP;
        if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end else begin
            case (st_q.phase)
                PH_RAISE_CKE: begin
                    st_d.cke   = 1'b1;
                    st_d.gap   = '0;
                    st_d.phase = PH_PRE_A;
                end
                PH_PRE_A: begin
                    st_d.cmd   = CMD_PRE_ALL;
                    st_d.gap   = RP_LOAD;
                    st_d.phase = PH_EXT_WR;
                end
                PH_EXT_WR: begin
                    st_d.cmd   = CMD_EXT_WR;
                    st_d.gap   = MRD_LOAD;
                    st_d.phase = PH_DLL_RST;
                end
                PH_DLL_RST: begin
                    st_d.cmd   = CMD_DLL_RST;
                    st_d.gap   = DLL_LOAD;
                    st_d.phase = PH_PRE_B;
                end
                PH_PRE_B: begin
                    st_d.cmd   = CMD_PRE_ALL;
                    st_d.gap   = RP_LOAD;
                    st_d.phase = PH_REFRESH;
                end
                PH_REFRESH: begin
                    st_d.cmd       = CMD_REFRESH;
                    st_d.gap       = RFC_LOAD;
                    st_d.refs_left = st_q.refs_left - 1'b1;
                    if (st_q.refs_left == REF_W'(1)) begin
                        st_d.phase = PH_OPER_WR;
                    end
                end
                PH_OPER_WR: begin
                    st_d.cmd   = CMD_OPER_WR;
                    st_d.gap   = MRD_LOAD;
                    st_d.phase = PH_FINISH;
                end
                PH_FINISH: begin
                    st_d.done  = 1'b1;
                    st_d.phase = PH_HOLD;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_RAISE_CKE;
            st_q.gap       <= SETTLE_LOAD;
            st_q.refs_left <= REF_LOAD;
            st_q.cke       <= 1'b0;
            st_q.cmd       <= CMD_NOP;
            st_q.done      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    ddr_init_cmd_enc u_enc (
        .cmd          (st_q.cmd),
        .ext_word     (ext_word),
        .dll_rst_word (dll_rst_word),
        .oper_word    (oper_word),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ba           (ba),
        .addr         (addr)
    );

    assign cke       = st_q.cke;
    assign init_done = st_q.done;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int DLL_LOCK_CYC = 200
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [11:0] addr,
    input logic        init_done
);

    localparam int WIN_W = $clog2(DLL_LOCK_CYC + 1);

    logic is_nop, is_pre, is_reg_wr;
    assign is_nop    = !cs_n && ras_n && cas_n && we_n;
    assign is_pre    = !cs_n && !ras_n && cas_n && !we_n;
    assign is_reg_wr = !cs_n && !ras_n && !cas_n && !we_n;

    // Cycles elapsed since the DLL-reset write, saturating
    logic             dll_armed;
    logic [WIN_W-1:0] dll_win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_armed <= 1'b0;
            dll_win   <= '0;
        end else if (is_reg_wr && ba == 2'b00 && addr[8]) begin
            dll_armed <= 1'b1;
            dll_win   <= WIN_W'(1);
        end else if (dll_armed && dll_win < WIN_W'(DLL_LOCK_CYC)) begin
            dll_win <= dll_win + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!cke && !init_done));

    // R2
    cke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R2
    cke_rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> is_nop);

    // R3
    no_cmd_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    // R4
    pre_all_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);

    // R5
    ext_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg_wr && ba[0]) |-> (ba[1] == 1'b0 && addr[11:2] == 10'd0 && !addr[0]));

    // R6
    reg_wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg_wr |=> is_nop);

    // R7
    dll_lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_armed && !is_nop) |-> (dll_win >= WIN_W'(DLL_LOCK_CYC)));

    // R9
    main_test_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg_wr && ba == 2'b00) |-> (!addr[7] && addr[11:9] == 3'd0));

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && is_nop));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .DLL_LOCK_CYC (DLL_LOCK_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

    localparam int CLK_NS = 10;

    localparam int P_PERIOD_PS = 7_000_000;
    localparam int P_DLL       = 200;
    localparam int P_RP        = 3;
    localparam int P_MRD       = 2;
    localparam int P_RFC       = 14;
    localparam int P_NREF      = 3;

    // 200 us at 7 us per cycle = 28.57, rounded up to 29
    localparam int SETTLE = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [11:0] addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ddr_init_seq #(
        .CLK_PERIOD_PS    (P_PERIOD_PS),
        .STABLE_US        (200),
        .DLL_LOCK_CYC     (P_DLL),
        .T_RP_CYC         (P_RP),
        .T_MRD_CYC        (P_MRD),
        .T_RFC_CYC        (P_RFC),
        .NUM_REFRESH      (P_NREF),
        .READ_LAT_X2      (5),
        .BURST_LEN        (8),
        .BURST_INTERLEAVE (1'b1),
        .DRIVE_HALF       (1'b1)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

    typedef struct {
        int          t;
        logic [3:0]  strobes;
        logic [1:0]  bank;
        logic [11:0] a;
        string       req;
    } slot_t;

    slot_t sched[$];
    int    t_done;

    task automatic add_slot(input int t, input logic [3:0] s, input logic [1:0] b,
                            input logic [11:0] a, input string req);
        slot_t e;
        e.t = t; e.strobes = s; e.bank = b; e.a = a; e.req = req;
        sched.push_back(e);
    endtask

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp, input int n);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d %s actual=%b expected=%b", req, n, what, act, exp);
        end
    endtask

    task automatic check_slot(input int n);
        logic [3:0]  s_exp = 4'b0111;
        logic [1:0]  b_exp = 2'b00;
        logic [11:0] a_exp = 12'd0;
        string       req   = "R3";
        foreach (sched[i]) begin
            if (sched[i].t == n) begin
                s_exp = sched[i].strobes;
                b_exp = sched[i].bank;
                a_exp = sched[i].a;
                req   = sched[i].req;
            end
        end
        checks++;
        if ({cs_n, ras_n, cas_n, we_n, ba, addr} !== {s_exp, b_exp, a_exp}) begin
            failures++;
            $display("FAIL %s cycle %0d pins actual=%b_%b_%h expected=%b_%b_%h",
                     req, n, {cs_n, ras_n, cas_n, we_n}, ba, addr, s_exp, b_exp, a_exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        int t;
        // Reference schedule built from the requirements
        t = SETTLE + 1;
        add_slot(t, 4'b0010, 2'b00, 12'h400, "R4");
        t += P_RP;
        // R5: BA0=1, A1=1 (half drive), A0=0
        add_slot(t, 4'b0000, 2'b01, 12'h002, "R5");
        t += P_MRD;
        // R6 R10: A8=1, latency 2.5 -> 110, interleave, length 8 -> 011
        add_slot(t, 4'b0000, 2'b00, 12'h16B, "R6 R10");
        t += P_DLL;
        add_slot(t, 4'b0010, 2'b00, 12'h400, "R7");
        t += P_RP;
        for (int i = 0; i < P_NREF; i++) begin
            add_slot(t, 4'b0001, 2'b00, 12'h000, "R8");
            t += P_RFC;
        end
        // R9 R10: A8=0, same operating fields
        add_slot(t, 4'b0000, 2'b00, 12'h06B, "R9 R10");
        t_done = t + P_MRD;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1", "cke", cke, 1'b0, -1);
        check_bit("R1", "init_done", init_done, 1'b0, -1);
        check_slot(-1);

        rst_n = 1'b1;
        for (int n = 0; n <= t_done + 12; n++) begin
            if (n > 0) @(negedge clk);
            // R2: cke low for exactly SETTLE cycles, then high
            check_bit("R2", "cke", cke, (n >= SETTLE), n);
            // R11: done rises T_MRD after final write and holds
            check_bit("R11", "init_done", init_done, (n >= t_done), n);
            check_slot(n);
        end
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule